// File: doc/BRIEF.md
# Multi-rate random-bit noise generator

This block drives a 5-bit word whose bits are rewritten at very different average rates. A weighted summing resistor DAC downstream turns the word into an analog signal whose spectrum leans toward low frequencies, which gives an inexpensive pink-like noise source. The block does not use clock division. On every sample strobe it draws fresh pseudo-random bits and uses them to pick at most one output bit, which it then overwrites with a random value. Because the threshold ladder gives each bit a fixed chance of being chosen, the high-order bits change often and the low-order bits change rarely.

The random source is a 32-bit right-shifting Galois LFSR. Each sample consumes nine LFSR steps. Eight of them form a selector byte and the ninth forms the data bit. A parameter sets how the steps are taken. The parallel variant takes all nine steps in the strobe clock. The serial variant takes one step per clock between strobes, which gives a shorter logic path. Both variants produce the same output sequence.

Top module: `mrnoise_gen`

## Requirements
- R1: The random source is a 32-bit Galois LFSR that shifts right. Each step emits the old bit 0. When that bit is 1, the shifted state is XORed with 0xD0000001. After reset the state is 0x00000001.
- R2: While `rst` is sampled high, `noise_o` becomes 5'b00000 on the next clock edge.
- R3: Each sample consumes exactly nine LFSR steps. The first emitted bit lands in selector bit 7 and the eighth in selector bit 0, because each new bit enters at bit 0 and pushes older bits left. The ninth emitted bit is the data value written to the output.
- R4: The selector, read as an unsigned number, picks the bit to update. Value 0 picks bit 0, 1..3 picks bit 1, 4..15 picks bit 2, 16..59 picks bit 3, and 60..233 picks bit 4. The picked bit takes the data value.
- R5: A selector of 234 or more leaves `noise_o` unchanged for that sample.
- R6: A sample changes at most one bit of `noise_o`, and all other bits keep their values.
- R7: `noise_o` changes only on a clock where `smp_en` is high. Between strobes the LFSR does not advance on behalf of the output, so the k-th strobe after reset always applies the k-th draw, whatever the gaps between strobes.
- R8: The LFSR state is never zero, so the draws keep yielding both data values indefinitely.
- R9: The serial variant (`SERIAL_DRAW`=1) produces the same output sequence as the parallel variant, provided strobes are at least 10 clocks apart and the first strobe comes at least 10 clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_en | input | 1 | Sample strobe; one high clock per sample period |
| noise_o | output | 5 | Registered noise word for the weighted DAC |

## Verification
Strobes arrive with randomly varied idle gaps between them, so the test shows that the output depends on the strobe count and not on elapsed clocks. The same strobe pattern drives the parallel and the serial variants side by side, which separates a per-clock stepping error from a selection error. Every sample is compared against a software LFSR and ladder. Each sample is tagged by the selector range the model produced, so a wrong threshold, a reversed selector bit order or an off-by-one step count each show up as a different kind of mismatch. A reset in the middle of the run and a long stretch with no strobe cover the seed reload and the hold behaviour.

// File: rtl/mrn_pkg.sv
package mrn_pkg;
   localparam int unsigned MRN_OUT_W = 5;
   localparam int unsigned MRN_SEL_W = 8;
   // upper (exclusive) selector bound for each output bit, lowest bit first
   localparam int unsigned MRN_LADDER [MRN_OUT_W] = '{1, 4, 16, 60, 234};
   localparam logic [31:0] MRN_MASK32 = 32'hD000_0001;
   localparam logic [31:0] MRN_SEED32 = 32'h0000_0001;
endpackage

// File: rtl/mrn_lfsr.sv
module mrn_lfsr #(
   parameter int unsigned W     = 32,
   parameter logic [W-1:0] MASK = 32'hD000_0001,
   parameter logic [W-1:0] SEED = 32'h0000_0001,
   parameter int unsigned STEPS = 9
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             adv,
   output logic [STEPS-1:0] emit
);
   if (W < 2) begin : g_bad_w
      $error("mrn_lfsr: W must be at least 2");
   end
   if (STEPS < 1 || STEPS > W) begin : g_bad_steps
      $error("mrn_lfsr: STEPS must lie in 1..W");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("mrn_lfsr: zero seed locks the register");
   end
   if (MASK[W-1] == 1'b0) begin : g_bad_mask
      $error("mrn_lfsr: MASK must reach the top bit");
   end

   logic [W-1:0] state_q;
   logic [W-1:0] state_n;

   // unrolled right-shift Galois steps; emit[k] is the k-th bit shifted out
   always_comb begin
      state_n = state_q;
      emit    = '0;
      for (int k = 0; k < int'(STEPS); k++) begin
         emit[k] = state_n[0];
         state_n = (state_n >> 1) ^ ({W{emit[k]}} & MASK);
      end
   end

   always_ff @(posedge clk) begin
      if (rst)
         state_q <= SEED;
      else if (adv)
         state_q <= state_n;
   end

   AST_SEED_ON_RESET: assert property (@(posedge clk)
      rst |=> state_q == SEED);                                  // R1
   AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (rst)
      state_q != '0);                                            // R8
endmodule

// File: rtl/mrn_ladder.sv
module mrn_ladder #(
   parameter int unsigned SEL_W = 8,
   parameter int unsigned OUT_W = 5,
   parameter int unsigned LADDER [OUT_W] = '{1, 4, 16, 60, 234}
) (
   input  logic [SEL_W-1:0] sel,
   output logic [OUT_W-1:0] mask
);
   for (genvar i = 0; i < int'(OUT_W); i++) begin : g_rung
      localparam logic [SEL_W-1:0] HI = SEL_W'(LADDER[i]);
      if (LADDER[i] >= (1 << SEL_W)) begin : g_bad_hi
         $error("mrn_ladder: threshold does not fit the selector");
      end
      if (i == 0) begin : g_first
         if (LADDER[0] == 0) begin : g_bad_first
            $error("mrn_ladder: first threshold must be nonzero");
         end
         assign mask[i] = (sel < HI);
      end else begin : g_next
         localparam logic [SEL_W-1:0] LO = SEL_W'(LADDER[i-1]);
         if (LADDER[i] <= LADDER[i-1]) begin : g_bad_order
            $error("mrn_ladder: thresholds must increase");
         end
         assign mask[i] = (sel >= LO) && (sel < HI);
      end
   end
endmodule

// File: rtl/mrn_outreg.sv
module mrn_outreg #(
   parameter int unsigned OUT_W = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic [OUT_W-1:0] mask,
   input  logic             data,
   output logic [OUT_W-1:0] word
);
   for (genvar i = 0; i < int'(OUT_W); i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (rst)
            word[i] <= 1'b0;
         else if (en && mask[i])
            word[i] <= data;
      end
   end

   AST_RESET_CLEARS: assert property (@(posedge clk)
      rst |=> word == '0);                                       // R2
   AST_HOLD_WITHOUT_EN: assert property (@(posedge clk) disable iff (rst)
      !en |=> $stable(word));                                    // R7
   AST_ONE_BIT_MAX: assert property (@(posedge clk) disable iff (rst)
      en |=> $countones(word ^ $past(word)) <= 1);               // R6
endmodule

// File: rtl/mrnoise_gen.sv
module mrnoise_gen
   import mrn_pkg::*;
#(
   parameter bit SERIAL_DRAW = 1'b0
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 smp_en,
   output logic [MRN_OUT_W-1:0] noise_o
);
   localparam int unsigned DRAW_N = MRN_SEL_W + 1;
   localparam int unsigned CNT_W  = $clog2(DRAW_N + 1);
   localparam logic [MRN_SEL_W-1:0] SKIP_AT = MRN_SEL_W'(MRN_LADDER[MRN_OUT_W-1]);

   if (MRN_OUT_W != 5) begin : g_bad_out
      $error("mrnoise_gen: output word must be 5 bits");
   end

   logic [MRN_SEL_W-1:0] sel;
   logic                 data;
   logic [MRN_OUT_W-1:0] upd_mask;

   if (!SERIAL_DRAW) begin : g_par
      logic [DRAW_N-1:0] bits;

      mrn_lfsr #(.W(32), .MASK(MRN_MASK32), .SEED(MRN_SEED32), .STEPS(DRAW_N)) u_lfsr (
         .clk  (clk),
         .rst  (rst),
         .adv  (smp_en),
         .emit (bits)
      );

      // first emitted bit ends up as the selector MSB
      for (genvar j = 0; j < int'(MRN_SEL_W); j++) begin : g_map
         assign sel[MRN_SEL_W-1-j] = bits[j];
      end
      assign data = bits[MRN_SEL_W];
   end else begin : g_ser
      logic [0:0]        bit1;
      logic [DRAW_N-1:0] draw_q;
      logic [CNT_W-1:0]  cnt_q;
      logic              step_en;

      assign step_en = (cnt_q != CNT_W'(DRAW_N));

      mrn_lfsr #(.W(32), .MASK(MRN_MASK32), .SEED(MRN_SEED32), .STEPS(1)) u_lfsr (
         .clk  (clk),
         .rst  (rst),
         .adv  (step_en),
         .emit (bit1)
      );

      always_ff @(posedge clk) begin
         if (rst) begin
            cnt_q  <= '0;
            draw_q <= '0;
         end else if (smp_en) begin
            cnt_q  <= '0;
         end else if (step_en) begin
            cnt_q  <= cnt_q + 1'b1;
            draw_q <= {draw_q[DRAW_N-2:0], bit1[0]};
         end
      end

      assign sel  = draw_q[DRAW_N-1:1];
      assign data = draw_q[0];

      AST_EN_SPACING: assert property (@(posedge clk) disable iff (rst)
         smp_en |-> cnt_q == CNT_W'(DRAW_N));                    // R9
   end

   mrn_ladder #(.SEL_W(MRN_SEL_W), .OUT_W(MRN_OUT_W), .LADDER(MRN_LADDER)) u_ladder (
      .sel  (sel),
      .mask (upd_mask)
   );

   mrn_outreg #(.OUT_W(MRN_OUT_W)) u_out (
      .clk  (clk),
      .rst  (rst),
      .en   (smp_en),
      .mask (upd_mask),
      .data (data),
      .word (noise_o)
   );

   AST_MASK_ONEHOT0: assert property (@(posedge clk) disable iff (rst)
      $onehot0(upd_mask));                                       // R6
   AST_HIGH_SEL_NO_UPDATE: assert property (@(posedge clk) disable iff (rst)
      (smp_en && sel >= SKIP_AT) |=> $stable(noise_o));          // R5
endmodule

// File: tb/sim_mrnoise_gen.sv
module sim_mrnoise_gen;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       smp_en = 1'b0;
   logic [4:0] out_p;
   logic [4:0] out_s;

   int n_chk  = 0;
   int n_fail = 0;
   int cyc    = 0;
   bit done   = 0;

   logic [31:0] m_state;
   logic [4:0]  m_out;
   bit          seen0, seen1;

   always #5 clk = ~clk;

   mrnoise_gen #(.SERIAL_DRAW(1'b0)) u0 (.clk(clk), .rst(rst), .smp_en(smp_en), .noise_o(out_p));
   mrnoise_gen #(.SERIAL_DRAW(1'b1)) u1 (.clk(clk), .rst(rst), .smp_en(smp_en), .noise_o(out_s));

   function automatic bit m_step();
      bit b = m_state[0];
      m_state = {1'b0, m_state[31:1]};
      if (b) m_state = m_state ^ 32'hD000_0001;
      return b;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [4:0] act, input logic [4:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      repeat (3) @(negedge clk);
      check(out_p == 5'b0, "R2 parallel reset", out_p, 5'b0);
      check(out_s == 5'b0, "R2 serial reset", out_s, 5'b0);
      rst = 1'b0;
      m_state = 32'h1;
      m_out = 5'b0;
      repeat (11) @(negedge clk);
   endtask

   task automatic sample(input int gap);
      logic [7:0] s = 8'h0;
      bit d;
      logic [4:0] prev = out_p;
      for (int k = 0; k < 8; k++) s = {s[6:0], m_step()};
      d = m_step();
      if      (s < 8'd1)   m_out[0] = d;
      else if (s < 8'd4)   m_out[1] = d;
      else if (s < 8'd16)  m_out[2] = d;
      else if (s < 8'd60)  m_out[3] = d;
      else if (s < 8'd234) m_out[4] = d;
      if (d) seen1 = 1; else seen0 = 1;
      smp_en = 1'b1;
      @(negedge clk);
      smp_en = 1'b0;
      if (s >= 8'd234)
         check(out_p == prev, "R5 high selector keeps word", out_p, prev);
      else
         check(out_p == m_out, "R4 R3 R1 ladder update", out_p, m_out);
      check(out_s == m_out, "R9 serial matches model", out_s, m_out);
      check($countones(out_p ^ prev) <= 1, "R6 single bit change", out_p ^ prev, 5'b0);
      repeat (gap) @(negedge clk);
      check(out_p == m_out, "R7 hold between strobes", out_p, m_out);
   endtask

   initial begin
      process::self().srandom(32'd1234);
      seen0 = 0; seen1 = 0;
      do_reset();
      for (int i = 0; i < 800; i++) sample(9 + int'($urandom % 8));
      sample(200);
      do_reset();
      for (int i = 0; i < 700; i++) sample(9 + int'($urandom % 12));
      check(seen0 && seen1, "R8 draws keep both data values",
            {3'b0, seen1, seen0}, 5'b00011);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule